// File: doc/BRIEF.md
# HDLC Transmit Packet Engine

This block turns host-written message bytes into a bit-synchronous HDLC line stream. The host first writes a payload byte into a holding register, then writes a control byte. Bit 0 of the control byte is the end-of-message tag. The control write, and only that write, commits the held byte and the tag together as one 9-bit entry into a 256-deep FIFO. The FIFO reports full, empty and its fill level back to the host.

A serializer advances one line bit each cycle in which the bit-enable input is high. Whenever no frame is in progress and the FIFO is empty, it sends 7Eh flags. It opens a frame as soon as an entry is waiting and no closing flags are still owed. It sends payload bytes least significant bit first and inserts a 0 after every five consecutive 1s. When it consumes a tagged byte, it appends the complemented CRC-16 frame check sequence and then at least two flags before the next frame can start. Each message must hold two or more payload bytes.

Top module: `hdlc_tx_engine`

## Requirements
- R1: A write with `wr_sel`=0 only loads the holding register and leaves `fifo_level` unchanged. A write with `wr_sel`=1 commits {`wr_data[0]`, held byte} as one entry, and `fifo_level` is one higher in the following cycle.
- R2: The FIFO holds at most 256 entries. A commit made while `fifo_full` is high is dropped: the level stays at 256 and the dropped byte never appears on the line.
- R3: `fifo_empty` is high exactly when the level is 0, and `fifo_full` is high exactly when the level is 256. After reset, empty=1, full=0, level=0 and `tx_bit`=1.
- R4: `tx_bit` is a register. It takes a new line bit in the cycle after a clock edge at which `bit_en` was high, and it holds its value otherwise. Payload bits go out bit 0 first and bit 7 last.
- R5: After five consecutive 1s inside payload or FCS, a 0 is inserted. Flags are never stuffed, so the line never carries more than six 1s in a row.
- R6: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB-first with preset FFFFh. The result is complemented and sent low byte first. For the payload "123456789" the FCS bytes are 6Eh then 90h.
- R7: After the FCS of a frame, at least two complete 7Eh flags precede the first bit of the next frame.
- R8: While the FIFO is empty and no frame is in progress, the line carries continuous 7Eh flags.
- R9: Each frame's payload equals the committed bytes of one message, in order, and the frame ends at the entry tagged end-of-message. This holds for every byte value, including 7Eh and FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0: payload byte write, 1: control byte write (commit) |
| wr_data | input | 8 | Write data; for control writes bit 0 is the end-of-message tag |
| bit_en | input | 1 | Line bit enable; one line bit per enabled cycle |
| fifo_full | output | 1 | FIFO holds 256 entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| fifo_level | output | 9 | Number of entries in the FIFO |
| tx_bit | output | 1 | Serial HDLC line bit |

## Verification
The FIFO status outputs change one cycle after the clock edge that samples a control write. The bench drives every write on a falling edge and reads the level at the next falling edge. A line bit appears on `tx_bit` one cycle after an enabled edge. The bench raises `bit_en` for exactly one edge and reads the bit at the following falling edge. It then holds `bit_en` low for a cycle and confirms the bit is unchanged. The collected bits feed a flag-delimiting, destuffing decoder in the bench, and every frame is compared with the messages written. The sweep covers byte values 0 to 253 in one full-FIFO message, plus short, stuffing-heavy and flag-like messages.

// File: rtl/hdlc_tx_pkg.sv
// Shared types and helpers for the HDLC transmit engine.
// Assumes byte-wide payload units and the reflected CRC-16 form.
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;   // x^16+x^12+x^5+1, reflected
    localparam logic [2:0]  STUFF_RUN  = 3'd5;

    // What the serializer shift register currently holds
    typedef enum logic [1:0] {
        U_FLAG   = 2'd0,
        U_DATA   = 2'd1,
        U_FCS_LO = 2'd2,
        U_FCS_HI = 2'd3
    } unit_e;

    // One LSB-first CRC step for a single line bit
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_step = (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_tx_host_if.sv
// Two-step host write port. A payload write loads a holding register.
// A control write commits the held byte and control bit 0 in the same cycle.
// Assumes the host writes payload before control for every byte.
module hdlc_tx_host_if
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              push,
    output logic [BYTE_W:0]   push_entry
);
    logic [BYTE_W-1:0] held_q;

    // Capture the payload byte on a payload write
    always_ff @(posedge clk) begin
        if (!rst_n)                held_q <= '0;
        else if (wr_en && !wr_sel) held_q <= wr_data;
    end

    // Commit on the control write: {eom tag, held byte}
    always_comb begin
        push       = wr_en && wr_sel;
        push_entry = {wr_data[0], held_q};
    end
endmodule

// File: rtl/hdlc_tx_fifo.sv
// Synchronous FIFO of {eom, byte} entries with level reporting.
// A push while full is dropped. A pop while empty is ignored.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module hdlc_tx_fifo #(
    parameter  int DEPTH = 256,
    parameter  int EW    = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_entry,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          do_wr, do_rd;

    // Qualify requests against the current occupancy
    always_comb begin
        do_wr = push && (count != LW'(DEPTH));
        do_rd = pop && (count != '0);
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= push_entry;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head entry and status outputs
    always_comb begin
        head  = mem[rd_ptr];
        full  = (count == LW'(DEPTH));
        empty = (count == '0);
        level = count;
    end
endmodule

// File: rtl/hdlc_tx_serializer.sv
// Bit serializer: idle flags, payload with zero insertion, FCS and closing flags.
// Advances one line bit per cycle with bit_en high. A stuffed 0 takes one
// slot and does not advance the shift register.
// Assumes messages of two or more bytes. If the FIFO runs dry mid-frame,
// the frame is closed with its FCS.
module hdlc_tx_serializer
    import hdlc_tx_pkg::*;
#(
    parameter  int CLOSE_FLAGS = 2,
    localparam int FLW         = $clog2(CLOSE_FLAGS + 1),
    localparam int CW          = $clog2(BYTE_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            fifo_empty,
    input  logic [BYTE_W:0] head,
    output logic            pop,
    output logic            tx_bit
);
    unit_e             kind_q, kind_nx;
    logic [BYTE_W-1:0] sh_q, sh_nx, fcs_hi_q;
    logic [CW-1:0]     cnt_q;
    logic [2:0]        ones_q;
    logic [15:0]       crc_q, crc_nx, fcs_nx;
    logic [FLW-1:0]    flags_left_q;
    logic              eom_q, take, step, byte_end, stuffable;

    // Per-bit decode: stuff slot, byte boundary, CRC after this bit
    always_comb begin
        stuffable = (kind_q != U_FLAG);
        step      = bit_en && (ones_q != STUFF_RUN);
        byte_end  = step && (cnt_q == CW'(BYTE_W - 1));
        crc_nx    = crc_step(crc_q, sh_q[0]);
        fcs_nx    = ~crc_nx;
    end

    // Choose the unit that follows the current one
    always_comb begin
        kind_nx = U_FLAG;
        sh_nx   = FLAG_BYTE;
        take    = 1'b0;
        case (kind_q)
            U_DATA: begin
                if (!eom_q && !fifo_empty) begin
                    kind_nx = U_DATA;
                    sh_nx   = head[BYTE_W-1:0];
                    take    = 1'b1;
                end else begin
                    kind_nx = U_FCS_LO;
                    sh_nx   = fcs_nx[7:0];
                end
            end
            U_FCS_LO: begin
                kind_nx = U_FCS_HI;
                sh_nx   = fcs_hi_q;
            end
            U_FCS_HI: begin
                kind_nx = U_FLAG;
                sh_nx   = FLAG_BYTE;
            end
            default: begin
                if (flags_left_q == '0 && !fifo_empty) begin
                    kind_nx = U_DATA;
                    sh_nx   = head[BYTE_W-1:0];
                    take    = 1'b1;
                end
            end
        endcase
        pop = byte_end && take;
    end

    // Line bit, stuffing run, shift register and frame state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q       <= U_FLAG;
            sh_q         <= FLAG_BYTE;
            cnt_q        <= '0;
            ones_q       <= '0;
            crc_q        <= CRC_PRESET;
            fcs_hi_q     <= '0;
            eom_q        <= 1'b0;
            flags_left_q <= '0;
            tx_bit       <= 1'b1;
        end else if (bit_en) begin
            if (!step) begin
                tx_bit <= 1'b0;
                ones_q <= '0;
            end else begin
                tx_bit <= sh_q[0];
                ones_q <= (stuffable && sh_q[0]) ? ones_q + 3'd1 : 3'd0;
                if (kind_q == U_DATA) crc_q <= crc_nx;
                if (!byte_end) begin
                    cnt_q <= cnt_q + 1'b1;
                    sh_q  <= sh_q >> 1;
                end else begin
                    cnt_q  <= '0;
                    kind_q <= kind_nx;
                    sh_q   <= sh_nx;
                    if (kind_q == U_DATA) fcs_hi_q <= fcs_nx[15:8];
                    if (take) eom_q <= head[BYTE_W];
                    if (take && kind_q == U_FLAG) crc_q <= CRC_PRESET;
                    if (kind_q == U_FCS_HI)
                        flags_left_q <= FLW'(CLOSE_FLAGS - 1);
                    else if (kind_q == U_FLAG && flags_left_q != '0)
                        flags_left_q <= flags_left_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_engine.sv
// Top: host write port, entry FIFO and HDLC serializer.
// Assumes bit_en paces the line and the host keeps messages >= 2 bytes.
module hdlc_tx_engine
    import hdlc_tx_pkg::*;
#(
    parameter  int DEPTH       = 256,
    parameter  int CLOSE_FLAGS = 2,
    localparam int LW          = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              bit_en,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic [LW-1:0]     fifo_level,
    output logic              tx_bit
);
    logic            push, pop;
    logic [BYTE_W:0] push_entry, head;

    hdlc_tx_host_if u_host (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .push(push), .push_entry(push_entry)
    );

    hdlc_tx_fifo #(.DEPTH(DEPTH), .EW(BYTE_W + 1)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
        .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty),
        .level(fifo_level)
    );

    hdlc_tx_serializer #(.CLOSE_FLAGS(CLOSE_FLAGS)) u_ser (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fifo_empty(fifo_empty),
        .head(head), .pop(pop), .tx_bit(tx_bit)
    );
endmodule

// File: rtl/hdlc_tx_engine_chk.sv
// Property checker bound to the engine top. It observes ports and the
// push/pop strobes that connect the write port, FIFO and serializer.
module hdlc_tx_engine_chk #(
    parameter int LW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input logic          pop,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic [LW-1:0] fifo_level,
    input logic          bit_en,
    input logic          tx_bit
);
    logic       en_d;
    logic [2:0] run_q;

    // Track consecutive 1s among the bits actually sent on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d  <= 1'b0;
            run_q <= '0;
        end else begin
            en_d <= bit_en;
            if (en_d) run_q <= tx_bit ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
        end
    end

    assert_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !fifo_full && !pop) |=> (fifo_level == $past(fifo_level) + 1'b1));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full && !pop) |=> (fifo_level == $past(fifo_level)));

    assert_status_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    assert_max_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_d && tx_bit) |-> (run_q < 3'd6));
endmodule

bind hdlc_tx_engine hdlc_tx_engine_chk #(.LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .bit_en(bit_en), .tx_bit(tx_bit)
);

// File: tb/hdlc_tx_engine_tb_top.sv
// Bench: fills the FIFO, streams the line, decodes frames and compares them.
module hdlc_tx_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, bit_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_full, fifo_empty, tx_bit;
    logic [8:0] fifo_level;

    always #10 clk = ~clk;   // 50 MHz

    hdlc_tx_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bit_en(bit_en), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .fifo_level(fifo_level), .tx_bit(tx_bit)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // expected frames
    logic [7:0] exp_buf [0:1023];
    int exp_off [0:15];
    int exp_len [0:15];
    int n_exp = 0, exp_fill = 0;
    logic [7:0] msg [0:255];
    int msg_len;

    // decoder state
    logic bits [0:4095];
    logic [7:0] rxb [0:511];
    int nbits = 0, ones = 0, stuffed = 0, run7 = 0, rx_count = 0;
    int flags_since = 2, hold_err = 0;
    bit synced = 1'b0;
    logic [15:0] hist = 16'h0, last_fcs = 16'h0;
    logic [7:0] first_a = 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int off, input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ rxb[off + i][k]) c = (c >> 1) ^ 16'h8408;
                else c = c >> 1;
            end
        return ~c;
    endfunction

    task automatic frame_done(input int len);
        int nb, n;
        bit same;
        logic [15:0] fcs;
        if (len % 8 != 0) begin
            chk(1'b0, "R9 frame bit length multiple of 8", len % 8, 0);
            rx_count++;
            return;
        end
        nb = len / 8;
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 8; k++) rxb[i][k] = bits[8 * i + k];
        n = nb - 2;
        fcs = ref_crc(0, n);
        last_fcs = {rxb[n + 1], rxb[n]};
        chk(last_fcs == fcs, "R6 frame FCS", int'(last_fcs), int'(fcs));
        if (rx_count > 0) chk(flags_since >= 2, "R7 flags between frames", flags_since, 2);
        if (rx_count == 1) first_a = rxb[0];
        if (rx_count < n_exp) begin
            same = (n == exp_len[rx_count]);
            for (int i = 0; i < n && same; i++)
                if (rxb[i] != exp_buf[exp_off[rx_count] + i]) same = 1'b0;
            chk(same, "R9 frame payload", n, exp_len[rx_count]);
        end else chk(1'b0, "R2 unexpected extra frame", rx_count, n_exp);
        rx_count++;
        flags_since = 1;
    endtask

    task automatic rx_bit(input logic b);
        hist = {hist[14:0], b};
        if (b) begin
            if (ones >= 6) run7++;
            ones++;
            if (nbits < 4096) bits[nbits] = 1'b1;
            nbits++;
        end else if (ones == 5) begin
            ones = 0;
            stuffed++;
        end else if (ones == 6) begin
            ones = 0;
            if (synced && nbits - 7 > 0) frame_done(nbits - 7);
            else if (synced) flags_since++;
            synced = 1'b1;
            nbits = 0;
        end else begin
            if (nbits < 4096) bits[nbits] = 1'b0;
            nbits++;
            ones = 0;
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_msg();
        exp_off[n_exp] = exp_fill;
        exp_len[n_exp] = msg_len;
        for (int i = 0; i < msg_len; i++) begin
            exp_buf[exp_fill] = msg[i];
            exp_fill++;
            wr(1'b0, msg[i]);
            wr(1'b1, (i == msg_len - 1) ? 8'h01 : 8'h00);
        end
        n_exp++;
    endtask

    task automatic step_bit();
        logic b;
        @(negedge clk);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        b = tx_bit;
        rx_bit(b);
        @(negedge clk);
        if (tx_bit !== b) hold_err++;
    endtask

    task automatic stream();
        while (!fifo_empty) step_bit();
        repeat (120) step_bit();
    endtask

    initial begin
        #(20 * 180000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_empty == 1'b1, "R3 reset empty", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R3 reset full", fifo_full, 0);
        chk(fifo_level == 9'd0, "R3 reset level", fifo_level, 0);
        chk(tx_bit == 1'b1, "R3 reset line idle high", tx_bit, 1);

        wr(1'b0, 8'h55);
        chk(fifo_level == 9'd0, "R1 payload write alone commits nothing", fifo_level, 0);

        // full-FIFO sweep: bytes 0..253 as one message, then a 2-byte message
        msg_len = 254;
        for (int i = 0; i < 254; i++) msg[i] = 8'(i);
        push_msg();
        chk(fifo_level == 9'd254, "R1 level after commits", fifo_level, 254);
        msg_len = 2; msg[0] = 8'h12; msg[1] = 8'h34;
        push_msg();
        chk(fifo_level == 9'd256, "R2 level at capacity", fifo_level, 256);
        chk(fifo_full == 1'b1, "R3 full at 256", fifo_full, 1);
        wr(1'b0, 8'hAB);
        wr(1'b1, 8'h01);
        chk(fifo_level == 9'd256, "R2 commit while full dropped", fifo_level, 256);

        stream();
        chk(fifo_empty == 1'b1 && fifo_level == 9'd0, "R3 drained to empty", fifo_level, 0);
        chk(rx_count == 2, "R2 frames after drain (dropped byte absent)", rx_count, 2);
        chk(first_a == 8'h12, "R4 LSB-first byte order", first_a, 8'h12);

        msg_len = 5;
        for (int i = 0; i < 5; i++) msg[i] = 8'hFF;
        push_msg();
        msg_len = 3; msg[0] = 8'h7E; msg[1] = 8'h7E; msg[2] = 8'h00;
        push_msg();
        msg_len = 9;
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        push_msg();
        chk(fifo_level == 9'd17, "R1 level after three messages", fifo_level, 17);

        stream();
        chk(rx_count == 5, "R9 frame count", rx_count, 5);
        chk(last_fcs == 16'h906E, "R6 FCS of 123456789", int'(last_fcs), 16'h906E);
        chk(stuffed > 0, "R5 zero insertion seen", stuffed, 1);
        chk(run7 == 0, "R5 no run of seven ones", run7, 0);
        chk(hold_err == 0, "R4 line bit held with bit_en low", hold_err, 0);
        chk(hist == 16'h7E7E, "R8 idle flags when empty", int'(hist), 16'h7E7E);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule